// File: doc/BRIEF.md
# Oscillator Trim and Clock-Output Register

This block is one special-function register for an on-chip oscillator. It holds a 6-bit trim code, which goes on to the analog oscillator, and one enable bit for a clock output. Software reaches it on a byte-wide register bus at address 0x96. The register takes whole-byte writes only and has no single-bit access.

The trim code and the enable bit are set only by the power-up reset. At that reset the enable bit clears and the trim code loads from a factory value input. After that they change only when software writes them. A read returns the live contents. Software can therefore set or clear the enable bit by read-modify-write and keep the trim code unchanged.

The block also drives one shared pin. The pin carries the CPU clock divided by two when two conditions hold: the enable bit is set, and the crystal oscillator is not using the pin. In every other case the pin carries ordinary port data. The divide-by-two comes from a toggle flip-flop that is held low while the output is off.

Top module: `osc_trim_ctl`

## Requirements
- R1: While `por_i` is high, the enable bit clears to 0 and the trim code loads `factory_trim_i`. After reset, a read of address 0x96 returns {0, 0, factory code}, and the pin carries port data.
- R2: A write with `sfr_addr_i` = 0x96 stores data bit 6 as the enable bit and data bits 5..0 as the trim code. The new value appears on `trim_o` and in reads from the next cycle on.
- R3: A write to any other address leaves the enable bit and the trim code unchanged.
- R4: Bit 7 of the register reads as 0 whatever value was written to it.
- R5: `sfr_rdata_o` is registered. It shows the register one cycle after the cycle in which 0x96 is on `sfr_addr_i`, and 0 one cycle after any other address.
- R6: With the enable bit at 1 and `xtal_in_use_i` at 0, `clk_pin_o` inverts on every clock cycle, which gives CCLK/2. The first cycle after the output is switched on drives 0, and the pin then alternates 1, 0, and so on.
- R7: With the enable bit at 0, `clk_pin_o` equals the `port_data_i` value of the previous cycle.
- R8: With `xtal_in_use_i` at 1, `clk_pin_o` equals the `port_data_i` value of the previous cycle, even when the enable bit is 1.
- R9: Changes on `factory_trim_i` outside power-up reset have no effect on the trim code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock (CCLK) |
| por_i | input | 1 | Power-up reset, synchronous, active high |
| sfr_addr_i | input | 8 | Register bus address |
| sfr_wr_i | input | 1 | Register bus write strobe |
| sfr_wdata_i | input | 8 | Register bus write data |
| sfr_rdata_o | output | 8 | Register bus read data, one cycle latency |
| factory_trim_i | input | 6 | Factory trim code, loaded at power-up reset |
| xtal_in_use_i | input | 1 | High when the crystal oscillator occupies the pin |
| port_data_i | input | 1 | Ordinary port data for the shared pin |
| clk_pin_o | output | 1 | Shared pin: CCLK/2 or port data |
| trim_o | output | 6 | Trim code to the oscillator |

## Verification
Each result is due a fixed number of cycles after its stimulus:

| Result | Due |
|---|---|
| Register write | on `trim_o` one edge after the write strobe |
| Read data | one edge after the address |
| Port data on the pin | one edge after it is driven |
| Divided clock | starts with 0 on the second edge after the enabling write |

The bench drives every input on the falling clock edge. It samples each output on a later falling edge, after exactly the number of rising edges listed above. A phase or latency error therefore shows up as a wrong value and not as a race.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  localparam int unsigned BUS_ADDR_W  = 8;
  localparam int unsigned BUS_DATA_W  = 8;
  localparam int unsigned TRIM_BITS   = 6;
  localparam logic [BUS_ADDR_W-1:0] TRIM_REG_ADDR = 8'h96;

  // Readback packing: reserved bits as zero, enable above the trim field
  function automatic logic [BUS_DATA_W-1:0] pack_readback(
    input logic                 en,
    input logic [TRIM_BITS-1:0] code
  );
    logic [BUS_DATA_W-1:0] v;
    v = '0;
    v[TRIM_BITS-1:0] = code;
    v[TRIM_BITS]     = en;
    return v;
  endfunction
endpackage

// File: rtl/trim_sfr_reg.sv
module trim_sfr_reg
  import osc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_ADDR_W,
  parameter int unsigned DATA_W = BUS_DATA_W,
  parameter int unsigned TRIM_W = TRIM_BITS,
  parameter logic [ADDR_W-1:0] REG_ADDR = TRIM_REG_ADDR
) (
  input  logic              clk,
  input  logic              por,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TRIM_W-1:0] factory,
  output logic              clk_en,
  output logic [TRIM_W-1:0] trim,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned EN_BIT = TRIM_W;
  localparam int unsigned RSV_W  = DATA_W - TRIM_W - 1;

  logic hit;
  logic wr_hit;
  assign hit    = (addr == REG_ADDR);
  assign wr_hit = wr && hit;

  // Register state: loaded at power-up reset, otherwise only by a write
  always_ff @(posedge clk) begin
    if (por) begin
      clk_en <= 1'b0;
      trim   <= factory;
    end else if (wr_hit) begin
      clk_en <= wdata[EN_BIT];
      trim   <= wdata[TRIM_W-1:0];
    end
  end

  // Registered read port, zero for foreign addresses
  logic [DATA_W-1:0] rd_q;
  always_ff @(posedge clk) begin
    if (por) rd_q <= '0;
    else     rd_q <= hit ? pack_readback(clk_en, trim) : '0;
  end
  assign rdata = rd_q;

  generate
    if (RSV_W > 0) begin : g_rsv
      logic unused_rsv;
      assign unused_rsv = ^wdata[DATA_W-1:EN_BIT+1];
    end
  endgenerate

  a_r3_no_foreign_write: assert property (@(posedge clk) disable iff (por)
    !wr_hit |=> ($stable(trim) && $stable(clk_en)))
    else $error("R3: register changed without a write to its address");

  a_r9_factory_ignored: assert property (@(posedge clk) disable iff (por)
    (!wr_hit && !$stable(factory)) |=> $stable(trim))
    else $error("R9: factory input leaked into trim");

  a_r5_foreign_read_zero: assert property (@(posedge clk) disable iff (por)
    !hit |=> (rdata == '0))
    else $error("R5: foreign read returned data");

  a_r4_rsv_zero: assert property (@(posedge clk) disable iff (por)
    hit |=> (rdata[DATA_W-1] == 1'b0))
    else $error("R4: reserved bit read as one");
endmodule

// File: rtl/clkout_pin_mux.sv
module clkout_pin_mux (
  input  logic clk,
  input  logic por,
  input  logic clk_en,
  input  logic xtal_busy,
  input  logic port_d,
  output logic pin
);
  logic active;
  logic div_q;
  logic pin_q;

  assign active = clk_en && !xtal_busy;

  // Toggle flip-flop: CCLK/2, parked low while the output is off
  always_ff @(posedge clk) begin
    if (por || !active) div_q <= 1'b0;
    else                div_q <= ~div_q;
  end

  // Registered pin driver
  always_ff @(posedge clk) begin
    if (por) pin_q <= 1'b0;
    else     pin_q <= active ? div_q : port_d;
  end
  assign pin = pin_q;

  a_r6_half_rate: assert property (@(posedge clk) disable iff (por)
    (active && $past(active)) |=> (pin != $past(pin)))
    else $error("R6: pin did not toggle while clock output active");

  a_r6_first_low: assert property (@(posedge clk) disable iff (por)
    $rose(active) |=> (pin == 1'b0))
    else $error("R6: clock output did not start low");

  a_r7_port_follow: assert property (@(posedge clk) disable iff (por)
    !clk_en |=> (pin == $past(port_d)))
    else $error("R7: pin did not follow port data while disabled");

  a_r8_xtal_port: assert property (@(posedge clk) disable iff (por)
    xtal_busy |=> (pin == $past(port_d)))
    else $error("R8: pin did not follow port data with crystal in use");
endmodule

// File: rtl/osc_trim_ctl.sv
module osc_trim_ctl
  import osc_trim_pkg::*;
#(
  parameter int unsigned ADDR_W = BUS_ADDR_W,
  parameter int unsigned DATA_W = BUS_DATA_W,
  parameter int unsigned TRIM_W = TRIM_BITS,
  parameter logic [ADDR_W-1:0] REG_ADDR = TRIM_REG_ADDR
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic [ADDR_W-1:0] sfr_addr_i,
  input  logic              sfr_wr_i,
  input  logic [DATA_W-1:0] sfr_wdata_i,
  output logic [DATA_W-1:0] sfr_rdata_o,
  input  logic [TRIM_W-1:0] factory_trim_i,
  input  logic              xtal_in_use_i,
  input  logic              port_data_i,
  output logic              clk_pin_o,
  output logic [TRIM_W-1:0] trim_o
);
  logic clk_en;

  trim_sfr_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TRIM_W(TRIM_W), .REG_ADDR(REG_ADDR)
  ) u_reg (
    .clk(clk_i), .por(por_i), .addr(sfr_addr_i), .wr(sfr_wr_i),
    .wdata(sfr_wdata_i), .factory(factory_trim_i),
    .clk_en(clk_en), .trim(trim_o), .rdata(sfr_rdata_o)
  );

  clkout_pin_mux u_pin (
    .clk(clk_i), .por(por_i), .clk_en(clk_en), .xtal_busy(xtal_in_use_i),
    .port_d(port_data_i), .pin(clk_pin_o)
  );

  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (por_i)
    (sfr_wr_i && sfr_addr_i == REG_ADDR) |=>
      (trim_o == $past(sfr_wdata_i[TRIM_W-1:0]) && clk_en == $past(sfr_wdata_i[TRIM_W])))
    else $error("R2: write data not stored");

  a_r1_por_load: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(por_i) |-> (trim_o == $past(factory_trim_i) && !clk_en))
    else $error("R1: power-up values wrong");
endmodule

// File: tb/tb_osc_trim_ctl.sv
`timescale 1ns/1ps
module tb_osc_trim_ctl;
  logic       clk = 1'b0;
  logic       por;
  logic [7:0] addr;
  logic       wr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [5:0] factory;
  logic       xtal;
  logic       port_d;
  logic       pin;
  logic [5:0] trim;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  osc_trim_ctl dut (
    .clk_i(clk), .por_i(por), .sfr_addr_i(addr), .sfr_wr_i(wr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .factory_trim_i(factory),
    .xtal_in_use_i(xtal), .port_data_i(port_d), .clk_pin_o(pin), .trim_o(trim)
  );

  // {address, write data, expected readback}
  localparam logic [23:0] VEC [7] = '{
    {8'h96, 8'h15, 8'h15},   // R2 plain trim write
    {8'h95, 8'h3F, 8'h15},   // R3 neighbour address
    {8'h96, 8'hFF, 8'h7F},   // R4 bit 7 dropped
    {8'h97, 8'h00, 8'h7F},   // R3 other neighbour
    {8'h96, 8'h80, 8'h00},   // R4 only bit 7 set
    {8'h96, 8'h4C, 8'h4C},   // R2 enable plus trim
    {8'h00, 8'hAA, 8'h4C}    // R3 address zero
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    addr = a;
    @(negedge clk);
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    por = 1'b1; addr = 8'h00; wr = 1'b0; wdata = 8'h00;
    factory = 6'h2A; xtal = 1'b0; port_d = 1'b0;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(trim == 6'h2A, "R1 trim", trim, 6'h2A);
    check(pin == 1'b0, "R1 pin", pin, 0);
    rd_chk(8'h96, 8'h2A, "R1 readback");
    // R5 foreign read
    rd_chk(8'h55, 8'h00, "R5 foreign read");

    // Vector table walk (R2 R3 R4 R5)
    for (int i = 0; i < 7; i++) begin
      wr_reg(VEC[i][23:16], VEC[i][15:8]);
      rd_chk(8'h96, VEC[i][7:0], "R2/R3/R4 table");
    end
    check(trim == 6'h0C, "R2 trim_o", trim, 6'h0C);

    // R6: enable already set (0x4C), xtal off; restart from disabled
    wr_reg(8'h96, 8'h0C);
    port_d = 1'b1;
    @(negedge clk);
    wr_reg(8'h96, 8'h4C);
    check(pin == 1'b1, "R6 lag port", pin, 1);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(pin == k[0], "R6 divide", pin, k[0]);
    end

    // R8: crystal in use, enable still set
    xtal = 1'b1;
    for (int k = 0; k < 4; k++) begin
      port_d = k[0] ^ 1'b1;
      @(negedge clk);
      check(pin == port_d, "R8 port follow", pin, port_d);
    end
    xtal = 1'b0;

    // R7: enable cleared
    wr_reg(8'h96, 8'h0C);
    for (int k = 0; k < 4; k++) begin
      port_d = k[0];
      @(negedge clk);
      check(pin == port_d, "R7 port follow", pin, port_d);
    end

    // R9: factory change ignored
    factory = 6'h11;
    repeat (2) @(negedge clk);
    rd_chk(8'h96, 8'h0C, "R9 factory ignored");
    check(trim == 6'h0C, "R9 trim_o", trim, 6'h0C);

    // R1 again: power-up reset reloads new factory code
    wr_reg(8'h96, 8'h7F);
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    rd_chk(8'h96, 8'h11, "R1 reload");

    finish_run();
  end
endmodule